// File: doc/BRIEF.md
# Deterministic Reed-Muller Test Pattern Generator

This block is the stimulus source for built-in self-test of a two-level AND-EXOR network made of positive-polarity product terms over `N` primary inputs. Besides the `N` function inputs it drives one extra control input, called x0 here, which feeds the head of the EXOR cascade in the network under test. The sequence it produces is the same for any function of that input width, so one generator serves every such network. It needs no seed.

A one-cycle `start` pulse in idle begins a run. The generator then emits one vector per clock with `valid` high, `N+4` vectors in all. The first four vectors step x0 and the data inputs through their four constant combinations. A walking-zero sweep across the data inputs follows. One cycle after the last vector `done` pulses, and the block returns to idle. The response compactor and the signature comparison sit outside this block.

Top module: `rm_test_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters idle. In idle, `valid`, `done` and every bit of `vec` are 0.
- R2: A `start` sampled high in idle makes `valid` rise at the next clock edge, and the first vector is present in that cycle.
- R3: `vec[0]` carries x0, and `vec[i]` carries data input xi for i = 1..N. The first four vectors are, in order: x0=0 with all data 0; x0=0 with all data 1; x0=1 with all data 0; x0=1 with all data 1.
- R4: After the four fixed vectors come N vectors. Each has x0=0 and exactly one data input at 0, with all other data inputs at 1. The zero sits on x1 in the first of these vectors and moves up one input per vector, ending on xN.
- R5: `valid` stays high for exactly N+4 consecutive cycles per run.
- R6: `done` is high for exactly one cycle, the cycle right after the last vector, with `valid` low. In the cycle after that the block is idle.
- R7: A `start` that arrives while vectors are being emitted, or in the `done` cycle, has no effect. The run continues unchanged, and no new run follows it.
- R8: A `start` in idle after a completed run produces the identical sequence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when sampled high in idle |
| vec | output | N+1 | Test vector: bit 0 is x0, bit i is xi |
| valid | output | 1 | High while `vec` holds a test vector |
| done | output | 1 | One-cycle pulse after the last vector |

## Verification
The hardest case to reach from the ports is a `start` that lands in the middle of a run or in the single `done` cycle. A faulty design could restart the sweep, reload the walking-zero register, or chain a second run, and in each case the vectors would look valid. The bench raises `start` at the edge where the fixed group gives way to the sweep, and again during the `done` cycle. It then compares every vector with the expected table and confirms that the block settles in idle and stays there.

// File: rtl/rm_test_gen.sv
module rm_test_gen #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic [N:0]   vec,
  output logic         valid,
  output logic         done
);
  localparam int CW = $clog2(N + 4);
  localparam logic [CW-1:0] LAST = CW'(N + 3);
  localparam logic [CW-1:0] NFIX = CW'(4);
  localparam logic [N-1:0] SEED = {{(N-1){1'b1}}, 1'b0};

  typedef enum logic [1:0] {IDLE, RUN, FIN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [N-1:0]  walk;
  logic          fixed;
  logic [N-1:0]  data;
  logic          x0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= IDLE;
      cnt  <= '0;
      walk <= SEED;
    end else begin
      case (st)
        IDLE: if (start) begin
          st   <= RUN;
          cnt  <= '0;
          walk <= SEED;
        end
        RUN: begin
          if (cnt == LAST) st <= FIN;
          else cnt <= cnt + 1'b1;
          if (!fixed) walk <= (walk << 1) | (walk >> (N - 1));
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign valid = (st == RUN);
  assign done  = (st == FIN);
  assign fixed = (cnt < NFIX);
  assign x0    = valid & fixed & cnt[1];
  assign data  = !valid ? '0 : (fixed ? {N{cnt[0]}} : walk);
  assign vec   = {data, x0};

  // R1: idle outputs quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!valid && !done) |-> (vec == '0));

  // R3: first vector of a run is all zeros
  a_r3_first_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> (vec == '0));

  // R4: sweep vectors carry one zero and x0 low
  a_r4_one_zero: assert property (@(posedge clk) disable iff (rst)
    (valid && cnt >= NFIX) |-> (vec[0] == 1'b0 && $countones(vec[N:1]) == N - 1));

  // R6: valid falls only into the done pulse, which lasts one cycle
  a_r6_done_follows: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(valid)) |-> done);
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !valid));
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && valid));

  // R7: start during a run does not cut it short
  a_r7_run_kept: assert property (@(posedge clk) disable iff (rst)
    (valid && start) |=> (valid || done));
endmodule

// File: tb/rm_test_gen_test.sv
module rm_test_gen_test;
  localparam int N = 5;
  localparam int NV = N + 4;
  localparam time TCLK = 10ns;

  localparam logic [N:0] EXP [NV] = '{
    6'b000000, 6'b111110, 6'b000001, 6'b111111,
    6'b111100, 6'b111010, 6'b110110, 6'b101110, 6'b011110
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N:0] vec;
  logic valid, done;
  int checks = 0;
  int errors = 0;

  rm_test_gen #(.N(N)) uut (
    .clk(clk), .rst(rst), .start(start),
    .vec(vec), .valid(valid), .done(done)
  );

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_seq(input bit poke);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < NV; i++) begin
      chk(valid === 1'b1, i == 0 ? "R2" : "R5", 32'(valid), 1);
      chk(vec === EXP[i], i < 4 ? "R3" : "R4", 32'(vec), 32'(EXP[i]));
      chk(done === 1'b0, "R6", 32'(done), 0);
      if (poke && (i == 3 || i == 6)) start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    chk(done === 1'b1 && valid === 1'b0, "R6", {30'd0, done, valid}, 32'h2);
    if (poke) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(done === 1'b0 && valid === 1'b0 && vec === '0, poke ? "R7" : "R6",
        {23'd0, vec, done, valid}, 0);
    @(negedge clk);
    chk(valid === 1'b0, poke ? "R7" : "R6", 32'(valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(valid === 1'b0 && done === 1'b0 && vec === '0, "R1", {23'd0, vec, done, valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(valid === 1'b0, "R1", 32'(valid), 0);
    run_seq(1'b0);
    run_seq(1'b1);
    run_seq(1'b0);   // R8 repeat gives identical sequence
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(valid === 1'b0 && done === 1'b0 && vec === '0, "R1", {23'd0, vec, done, valid}, 0);
    run_seq(1'b0);   // R8 clean run after mid-run reset
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule